// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. Software sets a reload value and a clock divider. It then enables the timer and must restart it at regular intervals. If software fails to do so, a down-counter runs out. The block then latches a timeout flag and signals the fault in one of two ways. It can hold an interrupt level, or it can emit a single reset pulse whose length software chooses.

Runaway code must not be able to alter or silence the timer by accident. For that reason, every write that changes configuration has to carry a fixed key pattern in its upper bits. The restart register acts only on one exact 32-bit value. A write whose key is wrong changes nothing.

The reload field is coarse. The counter starts from the field value shifted left by `SCALE_LOG2` bits, which is 12 by default, so one field step is worth 4096 counts. The counter moves down by one on each divider tick.

Top module: `keyed_wdt`

## Requirements
- R1: A write to the mode word (address 0x0) takes effect only when write-data bits [23:12] equal 0xABC. Any other key leaves every mode field unchanged.
- R2: In the mode word, bit 0 enables the timer, bit 1 enables the reset pulse, bit 2 enables the interrupt, and bits [5:4] select the pulse length. A mode read returns these fields as last written, with every other bit, the key included, read as zero.
- R3: A write to the control word (address 0x4) takes effect only when bits [31:16] equal 0x0092. Bits [13:2] hold the 12-bit reload field and bits [1:0] hold the divider select. A control read returns `{reload, select}` in those positions and zero elsewhere.
- R4: Divider select values 0, 1, 2 and 3 produce one tick every 8, 64, 512 and 4096 clock cycles respectively. The divider phase restarts on every reload.
- R5: A reload sets the count to the reload field times 2^SCALE_LOG2. The timeout occurs at the clock edge of the N-th tick after the reload, where N is that count, or N = 1 when the count is 0.
- R6: Writing exactly 0x00001999 to address 0x8 reloads the counter and clears the timeout flag. Any other value written there has no effect. Address 0x8 reads as zero.
- R7: On timeout, status bit 0 (address 0xC) becomes 1 and the counter stops. The flag stays at 1 until a valid restart clears it.
- R8: The interrupt output equals the timeout flag while the interrupt enable is 1, and it is 0 while the enable is 0.
- R9: When the reset enable is 1, a timeout starts one reset pulse on the same edge that sets the flag. The pulse lasts 2 << sel cycles, where sel is bits [5:4], giving 2, 4, 8 or 16 cycles. A new pulse cannot start while one is already running.
- R10: While the enable bit is 0, the counter and the divider hold still. A mode write that takes the enable bit from 0 to 1 performs a reload.
- R11: After reset, the mode word reads 0, the control word reads 0x3FFF, the status word reads 0, and both outputs are low.
- R12: A read returns its data one cycle after the read request. An access whose address does not exactly match one of the four word offsets reads zero and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and timer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 4 | Byte address of the register word |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| wdt_irq_o | output | 1 | Timeout interrupt level |
| wdt_rst_o | output | 1 | Timeout reset pulse |

## Verification
The checker watches the following properties on every cycle:
- writes with a wrong key leave the mode fields unchanged;
- the timeout flag persists until a valid restart;
- the counter stays frozen while the timer is disabled;
- a restart loads the scaled reload value;
- a reset pulse never runs longer than 16 cycles and only begins together with a new timeout.

The exact cycle at which a timeout occurs for each divider and reload value can only be shown by the bench's timed scenarios. The same holds for the measured pulse lengths, for a near-miss restart value that leaves the deadline where it was, and for re-enabling the timer, which restarts the deadline from the enabling edge.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

   localparam logic [3:0] OFS_MODE    = 4'h0;
   localparam logic [3:0] OFS_CTRL    = 4'h4;
   localparam logic [3:0] OFS_RESTART = 4'h8;
   localparam logic [3:0] OFS_STATUS  = 4'hC;

   typedef struct packed {
      logic [1:0] plen;
      logic       irq_en;
      logic       rst_en;
      logic       en;
   } wdt_mode_t;

endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
   import keyed_wdt_pkg::*;
#(
   parameter int              CRV_W       = 12,
   parameter logic [11:0]     MODE_KEY    = 12'hABC,
   parameter logic [15:0]     CTRL_KEY    = 16'h0092,
   parameter logic [31:0]     RESTART_KEY = 32'h0000_1999,
   parameter logic [CRV_W-1:0] RST_CRV    = '1,
   parameter logic [1:0]      RST_SEL     = 2'd3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [3:0]       addr_i,
   input  logic [31:0]      wdata_i,
   input  logic             we_i,
   input  logic             re_i,
   input  logic             flag_i,
   output logic [31:0]      rdata_o,
   output wdt_mode_t        mode_o,
   output logic [CRV_W-1:0] crv_o,
   output logic [1:0]       psel_o,
   output logic             restart_o,
   output logic             en_rise_o
);

   logic      mode_wr, ctrl_wr;
   wdt_mode_t mode_q;
   logic [CRV_W-1:0] crv_q;
   logic [1:0] psel_q;

   assign mode_wr   = we_i && (addr_i == OFS_MODE) && (wdata_i[23:12] == MODE_KEY);
   assign ctrl_wr   = we_i && (addr_i == OFS_CTRL) && (wdata_i[31:16] == CTRL_KEY);
   assign restart_o = we_i && (addr_i == OFS_RESTART) && (wdata_i == RESTART_KEY);
   assign en_rise_o = mode_wr && wdata_i[0] && !mode_q.en;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= '0;
         crv_q  <= RST_CRV;
         psel_q <= RST_SEL;
      end else begin
         if (mode_wr) begin
            mode_q.en     <= wdata_i[0];
            mode_q.rst_en <= wdata_i[1];
            mode_q.irq_en <= wdata_i[2];
            mode_q.plen   <= wdata_i[5:4];
         end
         if (ctrl_wr) begin
            crv_q  <= wdata_i[CRV_W+1:2];
            psel_q <= wdata_i[1:0];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_o <= '0;
      end else if (re_i) begin
         unique case (addr_i)
            OFS_MODE:   rdata_o <= {26'd0, mode_q.plen, 1'b0, mode_q.irq_en,
                                    mode_q.rst_en, mode_q.en};
            OFS_CTRL:   rdata_o <= 32'({crv_q, psel_q});
            OFS_STATUS: rdata_o <= {31'd0, flag_i};
            default:    rdata_o <= '0;
         endcase
      end
   end

   assign mode_o = mode_q;
   assign crv_o  = crv_q;
   assign psel_o = psel_q;

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int BASE_LOG2 = 3,
   parameter int STEP_LOG2 = 3,
   localparam int PRE_W    = BASE_LOG2 + 3 * STEP_LOG2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       run_i,
   input  logic       clear_i,
   input  logic [1:0] sel_i,
   output logic       tick_o
);

   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] div_m1;
   logic             wrap;

   always_comb begin
      div_m1 = PRE_W'((32'd1 << (BASE_LOG2 + STEP_LOG2 * 32'(sel_i))) - 32'd1);
   end

   assign wrap   = cnt_q >= div_m1;
   assign tick_o = run_i && !clear_i && wrap;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cnt_q <= '0;
      else if (clear_i || !run_i)  cnt_q <= (clear_i) ? '0 : cnt_q;
      else if (wrap)               cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
   parameter int               CRV_W      = 12,
   parameter int               SCALE_LOG2 = 12,
   parameter logic [CRV_W-1:0] RST_CRV    = '1,
   localparam int              CNT_W      = CRV_W + SCALE_LOG2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             reload_i,
   input  logic [CRV_W-1:0] crv_i,
   input  logic             tick_i,
   output logic             expire_o,
   output logic             flag_o,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;
   logic             last;

   assign last     = cnt_q <= CNT_W'(1);
   assign expire_o = tick_i && !flag_q && !reload_i && last;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= {RST_CRV, {SCALE_LOG2{1'b0}}};
         flag_q <= 1'b0;
      end else if (reload_i) begin
         cnt_q  <= {crv_i, {SCALE_LOG2{1'b0}}};
         flag_q <= 1'b0;
      end else if (tick_i && !flag_q) begin
         if (last) begin
            cnt_q  <= '0;
            flag_q <= 1'b1;
         end else begin
            cnt_q  <= cnt_q - 1'b1;
         end
      end
   end

   assign flag_o = flag_q;
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
   parameter int  LSEL_W = 2,
   localparam int PC_W   = (1 << LSEL_W) + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              fire_i,
   input  logic [LSEL_W-1:0] len_sel_i,
   output logic              pulse_o
);

   logic [PC_W-1:0] left_q;
   logic [PC_W-1:0] len;

   assign len = PC_W'(2) << len_sel_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         left_q <= '0;
      else if (fire_i && left_q == '0)     left_q <= len;
      else if (left_q != '0)               left_q <= left_q - 1'b1;
   end

   assign pulse_o = left_q != '0;

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import keyed_wdt_pkg::*;
#(
   parameter int               CRV_W       = 12,
   parameter int               SCALE_LOG2  = 12,
   parameter logic [11:0]      MODE_KEY    = 12'hABC,
   parameter logic [15:0]      CTRL_KEY    = 16'h0092,
   parameter logic [31:0]      RESTART_KEY = 32'h0000_1999,
   parameter logic [CRV_W-1:0] RST_CRV     = '1,
   localparam int              CNT_W       = CRV_W + SCALE_LOG2
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic [3:0]  bus_addr_i,
   input  logic [31:0] bus_wdata_i,
   input  logic        bus_we_i,
   input  logic        bus_re_i,
   output logic [31:0] bus_rdata_o,
   output logic        wdt_irq_o,
   output logic        wdt_rst_o
);

   if (CRV_W < 1 || CRV_W > 14) begin : g_bad_crv
      $error("keyed_wdt: CRV_W must lie in 1..14 to stay below the control key");
   end
   if (SCALE_LOG2 < 0 || CNT_W > 31) begin : g_bad_scale
      $error("keyed_wdt: SCALE_LOG2 out of range");
   end

   wdt_mode_t        mode;
   logic [CRV_W-1:0] crv;
   logic [1:0]       psel;
   logic             restart, en_rise, reload;
   logic             tick, expire, flag;
   logic [CNT_W-1:0] cnt;

   wdt_regfile #(
      .CRV_W(CRV_W), .MODE_KEY(MODE_KEY), .CTRL_KEY(CTRL_KEY),
      .RESTART_KEY(RESTART_KEY), .RST_CRV(RST_CRV), .RST_SEL(2'd3)
   ) i_regs (
      .clk_i, .rst_ni,
      .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .we_i(bus_we_i), .re_i(bus_re_i),
      .flag_i(flag), .rdata_o(bus_rdata_o),
      .mode_o(mode), .crv_o(crv), .psel_o(psel),
      .restart_o(restart), .en_rise_o(en_rise)
   );

   assign reload = restart || en_rise;

   wdt_prescaler #(.BASE_LOG2(3), .STEP_LOG2(3)) i_pre (
      .clk_i, .rst_ni, .run_i(mode.en), .clear_i(reload), .sel_i(psel), .tick_o(tick)
   );

   wdt_downcount #(.CRV_W(CRV_W), .SCALE_LOG2(SCALE_LOG2), .RST_CRV(RST_CRV)) i_down (
      .clk_i, .rst_ni, .reload_i(reload), .crv_i(crv), .tick_i(tick),
      .expire_o(expire), .flag_o(flag), .cnt_o(cnt)
   );

   wdt_pulse #(.LSEL_W(2)) i_pulse (
      .clk_i, .rst_ni, .fire_i(expire && mode.rst_en), .len_sel_i(mode.plen),
      .pulse_o(wdt_rst_o)
   );

   assign wdt_irq_o = flag && mode.irq_en;

endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
   parameter int          CRV_W      = 12,
   parameter int          SCALE_LOG2 = 12,
   parameter logic [11:0] MODE_KEY   = 12'hABC,
   localparam int         CNT_W      = CRV_W + SCALE_LOG2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [3:0]       bus_addr_i,
   input logic [31:0]      bus_wdata_i,
   input logic             bus_we_i,
   input logic [4:0]       mode_bits,
   input logic             restart,
   input logic             reload,
   input logic             flag,
   input logic             irq_en,
   input logic [CRV_W-1:0] crv,
   input logic [CNT_W-1:0] cnt,
   input logic             wdt_irq_o,
   input logic             wdt_rst_o
);

   localparam int MAX_PULSE = 16;
   logic [5:0] hi_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        hi_cnt <= '0;
      else if (wdt_rst_o) hi_cnt <= hi_cnt + 1'b1;
      else                hi_cnt <= '0;
   end

   AST_BADKEY_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_addr_i == 4'h0 && bus_wdata_i[23:12] != MODE_KEY) |=> $stable(mode_bits)); // R1

   AST_RESTART_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart |=> (cnt == {$past(crv), {SCALE_LOG2{1'b0}}}) && !flag); // R6

   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag && !restart) |=> flag); // R7

   AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wdt_irq_o) |-> ($rose(flag) || $rose(irq_en))); // R8

   AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wdt_rst_o |-> (32'(hi_cnt) < MAX_PULSE)); // R9

   AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wdt_rst_o) |-> $rose(flag)); // R9

   AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_bits[0] && !reload) |=> $stable(cnt)); // R10

endmodule

bind keyed_wdt keyed_wdt_chk #(.CRV_W(CRV_W), .SCALE_LOG2(SCALE_LOG2), .MODE_KEY(MODE_KEY)) i_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
   .bus_we_i(bus_we_i), .mode_bits(mode), .restart(restart), .reload(reload),
   .flag(flag), .irq_en(mode.irq_en), .crv(crv), .cnt(cnt),
   .wdt_irq_o(wdt_irq_o), .wdt_rst_o(wdt_rst_o)
);

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;

   localparam int S = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        we = 1'b0, re = 1'b0;
   logic [31:0] rdata;
   logic        irq, rst_o;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   keyed_wdt #(.SCALE_LOG2(S)) i_keyed_wdt (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_we_i(we), .bus_re_i(re), .bus_rdata_o(rdata),
      .wdt_irq_o(irq), .wdt_rst_o(rst_o)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1'b1;
      @(posedge clk);
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; re = 1'b1;
      @(posedge clk);
      @(negedge clk); re = 1'b0; d = rdata;
   endtask

   function automatic logic [31:0] mode_word(int plen, bit ie, bit re_, bit en);
      return 32'h00AB_C000 | 32'(plen << 4) | 32'(ie) << 2 | 32'(re_) << 1 | 32'(en);
   endfunction

   // expected cycles from reload edge to timeout edge (R4, R5)
   function automatic int deadline(int crv, int sel);
      int n = (crv == 0) ? 1 : crv << S;
      return n * (8 << (3 * sel));
   endfunction

   task automatic run_expiry(int crv, int sel, bit ie, bit re_, int plen);
      logic [31:0] d;
      int k = deadline(crv, sel);
      int len = 0;
      wr(4'h4, 32'h0092_0000 | 32'(crv << 2) | 32'(sel));
      wr(4'h0, mode_word(plen, ie, re_, 1'b1));
      wr(4'h8, 32'h0000_1999);
      repeat (k - 1) @(posedge clk);
      @(negedge clk);
      chk("R5 irq before deadline", 32'(irq), 0);
      chk("R9 rst before deadline", 32'(rst_o), 0);
      @(posedge clk); @(negedge clk);
      chk("R8 irq at deadline", 32'(irq), 32'(ie));
      while (rst_o && len < 64) begin len++; @(negedge clk); end
      chk("R9 pulse length", 32'(len), re_ ? 32'(2 << plen) : 0);
      rd(4'hC, d);
      chk("R7 status after timeout", d, 1);
   endtask

   initial begin : main
      logic [31:0] d;
      int k;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R11 reset state, R12 read latency
      chk("R11 irq at reset", 32'(irq), 0);
      chk("R11 rst at reset", 32'(rst_o), 0);
      rd(4'h0, d); chk("R11 mode reset", d, 0);
      rd(4'h4, d); chk("R11 ctrl reset", d, 32'h3FFF);
      rd(4'hC, d); chk("R11 status reset", d, 0);

      // R1/R2 mode key and field readback
      wr(4'h0, 32'h00AB_C036); rd(4'h0, d); chk("R2 mode readback", d, 32'h36);
      wr(4'h0, 32'h00AB_B001); rd(4'h0, d); chk("R1 bad key ignored", d, 32'h36);
      wr(4'h0, 32'hFFAB_CFFE); rd(4'h0, d); chk("R2 unimplemented read zero", d, 32'h36);
      wr(4'h0, 32'h00AB_C000); rd(4'h0, d); chk("R2 cleared", d, 0);

      // R3 control key and readback
      wr(4'h4, 32'h0092_1235); rd(4'h4, d); chk("R3 ctrl readback", d, 32'h1235);
      wr(4'h4, 32'h0093_0000); rd(4'h4, d); chk("R3 bad key ignored", d, 32'h1235);
      wr(4'h4, 32'h0092_0000 | 32'hFFFF); rd(4'h4, d); chk("R3 upper bits zero", d, 32'h3FFF);
      rd(4'h8, d); chk("R6 restart reads zero", d, 0);
      rd(4'h2, d); chk("R12 misaligned reads zero", d, 0);

      // R4/R5/R8 sweep of reload values at divide-by-8
      for (int c = 0; c <= 6; c++) run_expiry(c, 0, 1'b1, 1'b0, 0);
      // R9 pulse length sweep
      for (int p = 0; p <= 3; p++) run_expiry(1, 0, 1'b0, 1'b1, p);
      // R4 other dividers
      for (int s = 1; s <= 3; s++) run_expiry(1, s, 1'b1, 1'b1, 3);

      // R6 near-miss restart keeps the deadline
      k = deadline(2, 0);
      wr(4'h4, 32'h0092_0008);
      wr(4'h8, 32'h0000_1999);
      repeat (100) @(posedge clk);
      wr(4'h8, 32'h0000_1998);
      repeat (k - 1 - 101) @(posedge clk);
      @(negedge clk); chk("R6 bad restart no reload (low)", 32'(irq), 0);
      @(posedge clk); @(negedge clk); chk("R6 bad restart no reload (high)", 32'(irq), 1);
      wr(4'h8, 32'h0001_1999); rd(4'hC, d); chk("R7 flag held on bad restart", d, 1);
      wr(4'h8, 32'h0000_1999); rd(4'hC, d); chk("R7 flag cleared by restart", d, 0);

      // R10 disable freezes, re-enable reloads
      k = deadline(1, 0);
      wr(4'h4, 32'h0092_0004);
      wr(4'h8, 32'h0000_1999);
      repeat (50) @(posedge clk);
      wr(4'h0, mode_word(0, 1'b1, 1'b0, 1'b0));
      repeat (500) @(posedge clk);
      @(negedge clk); chk("R10 frozen irq", 32'(irq), 0);
      rd(4'hC, d); chk("R10 frozen status", d, 0);
      wr(4'h0, mode_word(0, 1'b1, 1'b0, 1'b1));
      repeat (k - 1) @(posedge clk);
      @(negedge clk); chk("R10 re-enable reload (low)", 32'(irq), 0);
      @(posedge clk); @(negedge clk); chk("R10 re-enable reload (high)", 32'(irq), 1);
      wr(4'h0, mode_word(0, 1'b0, 1'b0, 1'b1));
      @(negedge clk); chk("R8 irq masked", 32'(irq), 0);

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule